// File: doc/BRIEF.md
# Edge-Sensing Interrupt Pin Port

This block serves seven external pins, numbered 1 to 7. Each pin can work as a general-purpose line, driven from an output data register when its direction bit is set. Each pin can also act as an interrupt source. A 2-bit mode per pin selects how the pin raises a request: an active-low level, a rising edge, a falling edge, or either edge. Edge events are caught in sticky flags, which software clears by writing ones. Level requests are not stored; they follow the synchronized pin.

Software reaches the block through a simple single-cycle register bus. Read data and the error response are combinational in the cycle of the request, and a write takes effect at the clock edge that ends it. The configuration registers (mode, direction, interrupt enable) answer only to supervisor accesses. A user access to one of them is refused with a bus error and changes nothing. Each pin has its own interrupt line, formed as its enable bit ANDed with its request. Every pad input passes through a two-flop synchronizer. Edge sensing watches the real pad level, so it also works on pins that the block itself drives.

Top module: `edge_port_irq`

## Requirements
- R1: After reset, the mode register reads 0x0000, direction 0x00, interrupt enable 0x00, output data 0xFF and flags 0x00, and all interrupt lines are low.
- R2: Register offsets are: mode 0 (16 bits, pin n's field in bits 2n+1:2n), direction 2, interrupt enable 3, output data 4, pin data 5, flags 6. Bits 1:0 of the mode register read 0. Bit 0 of direction, enable, flags and pin data reads 0. Output data holds all 8 bits.
- R3: A user-mode access (bus_sup=0) to offset 0, 2 or 3 asserts bus_err in the same cycle, returns zero and leaves the register unchanged. Offsets 4, 5 and 6 accept user accesses without error.
- R4: Pin data (offset 5) bit n returns pin n's pad level after two clock edges of synchronization.
- R5: pin_oe equals direction bits 7:1 and pin_out equals output data bits 7:1.
- R6: In mode 00 the request of pin n is active while the synchronized pad is 0, without latching. The interrupt line follows the pad two edges after it changes, and no flag is set.
- R7: In mode 01 a rising pad edge sets flag n at the third clock edge after the pad changes. A falling edge sets nothing.
- R8: In mode 10 a falling pad edge sets flag n. A rising edge sets nothing.
- R9: In mode 11 both rising and falling pad edges set flag n.
- R10: A set flag stays set after the pad returns to its idle level. Writing 1 to a flag bit at offset 6 clears it; writing 0 leaves it unchanged.
- R11: If an edge event and a write-one clear hit the same flag in the same cycle, the flag stays set.
- R12: Edge detection observes the pad whether the pin is an input or an output.
- R13: Interrupt line n is enable bit n ANDed with the request (the flag in edge modes). With the enable bit clear, the flag still sets but the line stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_sup | input | 1 | 1 = supervisor access, 0 = user |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 16 | Write data (8-bit registers use bits 7:0) |
| bus_rdata | output | 16 | Read data, same cycle |
| bus_err | output | 1 | Access refused |
| pin_in | input | 7 | Pad levels, pins 7..1 |
| pin_out | output | 7 | Output drive value, pins 7..1 |
| pin_oe | output | 7 | Output enable, pins 7..1 |
| irq | output | 7 | Per-pin interrupt lines, pins 7..1 |

## Verification
A wrong synchronizer or previous-sample flop shows up as a flag that rises one edge early or late, or as a flag that appears on the wrong polarity. The bench samples the interrupt lines at the exact edge count to catch this. A corrupted flag state persists and shows on irq and on reads of offset 6 until software clears it, so it shows within the next flag read. A broken supervisor gate is visible in the very cycle of the access, through bus_err, and afterwards through the register value read back.

// File: rtl/ep_pkg.sv
package ep_pkg;
  typedef enum logic [1:0] {
    MODE_LEVEL = 2'b00,
    MODE_RISE  = 2'b01,
    MODE_FALL  = 2'b10,
    MODE_BOTH  = 2'b11
  } ep_mode_e;

  localparam logic [2:0] OFS_MODE = 3'd0;
  localparam logic [2:0] OFS_DIR  = 3'd2;
  localparam logic [2:0] OFS_IEN  = 3'd3;
  localparam logic [2:0] OFS_DOUT = 3'd4;
  localparam logic [2:0] OFS_PIN  = 3'd5;
  localparam logic [2:0] OFS_FLAG = 3'd6;
endpackage

// File: rtl/ep_sync.sv
module ep_sync #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '1;
      q      <= '1;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/ep_pin_cell.sv
module ep_pin_cell
  import ep_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  ep_mode_e mode,
  input  logic     smp,
  input  logic     clr,
  output logic     flag,
  output logic     req
);
  logic prev;
  logic rise, fall, hit;

  assign rise = smp & ~prev;
  assign fall = ~smp & prev;

  always_comb begin
    unique case (mode)
      MODE_RISE: hit = rise;
      MODE_FALL: hit = fall;
      MODE_BOTH: hit = rise | fall;
      default:   hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev <= 1'b1;
      flag <= 1'b0;
    end else begin
      prev <= smp;
      flag <= hit | (flag & ~clr);
    end
  end

  assign req = (mode == MODE_LEVEL) ? ~smp : flag;
endmodule

// File: rtl/edge_port_irq.sv
module edge_port_irq
  import ep_pkg::*;
#(
  parameter int NPINS = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_req,
  input  logic               bus_wr,
  input  logic               bus_sup,
  input  logic [2:0]         bus_addr,
  input  logic [2*NPINS+1:0] bus_wdata,
  output logic [2*NPINS+1:0] bus_rdata,
  output logic               bus_err,
  input  logic [NPINS:1]     pin_in,
  output logic [NPINS:1]     pin_out,
  output logic [NPINS:1]     pin_oe,
  output logic [NPINS:1]     irq
);
  localparam int DW = NPINS + 1;
  localparam int AW = 2 * DW;

  logic [AW-1:2]    mode_q;
  logic [NPINS:1]   dir_q;
  logic [NPINS:1]   ien_q;
  logic [DW-1:0]    dout_q;
  logic [NPINS:1]   pin_sync;
  logic [NPINS:1]   flag_q;
  logic [NPINS:1]   flag_clr;
  logic [NPINS:1]   pin_req;
  logic             sup_only;
  logic             wr_ok;

  // supervisor-gated offsets
  assign sup_only = (bus_addr == OFS_MODE) || (bus_addr == OFS_DIR) ||
                    (bus_addr == OFS_IEN);
  assign bus_err  = bus_req & ~bus_sup & sup_only;
  assign wr_ok    = bus_req & bus_wr & ~bus_err;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      dir_q  <= '0;
      ien_q  <= '0;
      dout_q <= '1;
    end else if (wr_ok) begin
      case (bus_addr)
        OFS_MODE: mode_q <= bus_wdata[AW-1:2];
        OFS_DIR:  dir_q  <= bus_wdata[NPINS:1];
        OFS_IEN:  ien_q  <= bus_wdata[NPINS:1];
        OFS_DOUT: dout_q <= bus_wdata[DW-1:0];
        default: ;
      endcase
    end
  end

  assign flag_clr = (wr_ok && bus_addr == OFS_FLAG) ? bus_wdata[NPINS:1] : '0;

  ep_sync #(.W(NPINS)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pin_in),
    .q     (pin_sync)
  );

  for (genvar i = 1; i <= NPINS; i++) begin : g_pin
    ep_pin_cell u_cell (
      .clk   (clk),
      .rst_n (rst_n),
      .mode  (ep_mode_e'(mode_q[2*i+1:2*i])),
      .smp   (pin_sync[i]),
      .clr   (flag_clr[i]),
      .flag  (flag_q[i]),
      .req   (pin_req[i])
    );
  end

  assign irq     = ien_q & pin_req;
  assign pin_out = dout_q[NPINS:1];
  assign pin_oe  = dir_q;

  always_comb begin
    bus_rdata = '0;
    if (bus_req && !bus_err) begin
      case (bus_addr)
        OFS_MODE: bus_rdata        = {mode_q, 2'b00};
        OFS_DIR:  bus_rdata[DW-1:0] = {dir_q, 1'b0};
        OFS_IEN:  bus_rdata[DW-1:0] = {ien_q, 1'b0};
        OFS_DOUT: bus_rdata[DW-1:0] = dout_q;
        OFS_PIN:  bus_rdata[DW-1:0] = {pin_sync, 1'b0};
        OFS_FLAG: bus_rdata[DW-1:0] = {flag_q, 1'b0};
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/edge_port_irq_chk.sv
module edge_port_irq_chk #(
  parameter int NPINS = 7
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bus_req,
  input logic               bus_wr,
  input logic               bus_sup,
  input logic [2:0]         bus_addr,
  input logic [2*NPINS+1:0] bus_wdata,
  input logic [2*NPINS+1:0] bus_rdata,
  input logic               bus_err,
  input logic [NPINS:1]     irq,
  input logic [NPINS:1]     flag_q,
  input logic [NPINS:1]     ien_q,
  input logic [2*NPINS+1:2] mode_q
);
  logic [NPINS:1] w1c_mask;
  logic           cfg_off;
  assign w1c_mask = (bus_req && bus_wr && !bus_err && bus_addr == 3'd6) ?
                    bus_wdata[NPINS:1] : '0;
  assign cfg_off  = (bus_addr == 3'd0) || (bus_addr == 3'd2) || (bus_addr == 3'd3);

  AST_USER_CFG_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_sup && cfg_off) |-> (bus_err && bus_rdata == '0)); // R3
  AST_USER_DATA_OK: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !cfg_off) |-> !bus_err); // R3
  AST_MODE_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_wr && bus_sup && bus_addr == 3'd0) |-> (bus_rdata[1:0] == 2'b00)); // R2
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flag_q & $past(flag_q) & ~$past(w1c_mask)) == ($past(flag_q) & ~$past(w1c_mask)))); // R10
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq & ~ien_q) == '0)); // R13

  for (genvar i = 1; i <= NPINS; i++) begin : g_chk
    AST_FLAG_EDGE_MODE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_q[i]) |-> ($past(mode_q[2*i+1:2*i]) != 2'b00)); // R6
  end
endmodule

bind edge_port_irq edge_port_irq_chk #(.NPINS(NPINS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_req   (bus_req),
  .bus_wr    (bus_wr),
  .bus_sup   (bus_sup),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .bus_err   (bus_err),
  .irq       (irq),
  .flag_q    (flag_q),
  .ien_q     (ien_q),
  .mode_q    (mode_q)
);

// File: tb/edge_port_irq_bench.sv
module edge_port_irq_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_req = 1'b0, bus_wr = 1'b0, bus_sup = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        bus_err;
  logic [7:1]  ext = '1;
  logic [7:1]  pin_in, pin_out, pin_oe, irq;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  assign pin_in = (pin_oe & pin_out) | (~pin_oe & ext);

  always #(CLK_PERIOD/2) clk = ~clk;

  edge_port_irq u_edge_port_irq (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_wr(bus_wr),
    .bus_sup(bus_sup), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_err(bus_err), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic bwr(input logic [2:0] a, input logic [15:0] d, input logic sup, output logic err);
    @(negedge clk);
    bus_req = 1; bus_wr = 1; bus_sup = sup; bus_addr = a; bus_wdata = d;
    #1 err = bus_err;
    @(negedge clk);
    bus_req = 0; bus_wr = 0;
  endtask

  task automatic brd(input logic [2:0] a, input logic sup, output logic [15:0] d, output logic err);
    @(negedge clk);
    bus_req = 1; bus_wr = 0; bus_sup = sup; bus_addr = a;
    #1 d = bus_rdata; err = bus_err;
    @(negedge clk);
    bus_req = 0;
  endtask

  task automatic swr(input logic [2:0] a, input logic [15:0] d);
    logic e;
    bwr(a, d, 1'b1, e);
  endtask

  function automatic logic [15:0] dummy(input logic [15:0] x);
    return x;
  endfunction

  task automatic sread(input logic [2:0] a, output logic [15:0] d);
    logic e;
    brd(a, 1'b1, d, e);
  endtask

  task automatic t_reset;
    logic [15:0] d;
    sread(3'd0, d); chk("R1 mode reset", d, 16'h0000);
    sread(3'd2, d); chk("R1 dir reset", d, 16'h0000);
    sread(3'd3, d); chk("R1 ien reset", d, 16'h0000);
    sread(3'd4, d); chk("R1 dout reset", d, 16'h00FF);
    sread(3'd6, d); chk("R1 flag reset", d, 16'h0000);
    chk("R1 irq reset", {9'd0, irq}, 16'h0000);
    sread(3'd5, d); chk("R4 pin data idle", d, 16'h00FE);
  endtask

  task automatic t_access;
    logic [15:0] d; logic e;
    swr(3'd0, 16'hFFFF); sread(3'd0, d); chk("R2 mode low bits", d, 16'hFFFC);
    swr(3'd2, 16'h00FF); sread(3'd2, d); chk("R2 dir bit0", d, 16'h00FE);
    swr(3'd2, 16'h0000);
    bwr(3'd0, 16'h0000, 1'b0, e); chk("R3 user write err", {15'd0, e}, 16'h0001);
    sread(3'd0, d); chk("R3 user write no effect", d, 16'hFFFC);
    brd(3'd3, 1'b0, d, e); chk("R3 user read err", {15'd0, e}, 16'h0001);
    chk("R3 user read zero", d, 16'h0000);
    bwr(3'd4, 16'h0055, 1'b0, e); chk("R3 user data ok", {15'd0, e}, 16'h0000);
    sread(3'd4, d); chk("R2 dout 8 bits", d, 16'h0055);
    swr(3'd0, 16'h0000); swr(3'd4, 16'h00FF);
  endtask

  task automatic t_output;
    swr(3'd2, 16'h000A); swr(3'd4, 16'h0000);
    chk("R5 oe", {9'd0, pin_oe}, 16'h0005);
    chk("R5 out low", {9'd0, pin_out}, 16'h0000);
    swr(3'd4, 16'h00FF);
    chk("R5 out high", {9'd0, pin_out}, 16'h007F);
    swr(3'd2, 16'h0000);
  endtask

  task automatic t_pindata;
    @(negedge clk);
    bus_req = 1; bus_wr = 0; bus_sup = 1; bus_addr = 3'd5; ext[2] = 0;
    @(negedge clk); chk("R4 pin data after 1 edge", bus_rdata, 16'h00FE);
    @(negedge clk); chk("R4 pin data after 2 edges", bus_rdata, 16'h00FA);
    bus_req = 0; ext[2] = 1;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_level;
    logic [15:0] d;
    swr(3'd3, 16'h0010);
    chk("R6 level idle", {9'd0, irq}, 16'h0000);
    ext[4] = 0;
    @(negedge clk); chk("R6 level after 1 edge", {9'd0, irq}, 16'h0000);
    @(negedge clk); chk("R6 level after 2 edges", {9'd0, irq}, 16'h0008);
    ext[4] = 1;
    repeat (2) @(negedge clk); chk("R6 level released", {9'd0, irq}, 16'h0000);
    sread(3'd6, d); chk("R6 no flag", d, 16'h0000);
    swr(3'd3, 16'h0000);
  endtask

  task automatic t_rise;
    logic [15:0] d;
    swr(3'd0, 16'h0010); swr(3'd3, 16'h0004);
    ext[2] = 0; repeat (3) @(negedge clk);
    sread(3'd6, d); chk("R7 falling ignored", d, 16'h0000);
    ext[2] = 1;
    repeat (2) @(negedge clk); chk("R7 not yet", {9'd0, irq}, 16'h0000);
    @(negedge clk); chk("R7 rise flag irq", {9'd0, irq}, 16'h0002);
    ext[2] = 0; repeat (3) @(negedge clk);
    chk("R10 sticky irq", {9'd0, irq}, 16'h0002);
    swr(3'd6, 16'h0000); sread(3'd6, d); chk("R10 write zero keeps", d, 16'h0004);
    swr(3'd6, 16'h0004); sread(3'd6, d); chk("R10 write one clears", d, 16'h0000);
    chk("R10 irq cleared", {9'd0, irq}, 16'h0000);
    ext[2] = 1; repeat (3) @(negedge clk);
    swr(3'd6, 16'h00FE); swr(3'd3, 16'h0000);
  endtask

  task automatic t_fall;
    logic [15:0] d;
    swr(3'd0, 16'h0800);
    ext[5] = 0; repeat (3) @(negedge clk);
    sread(3'd6, d); chk("R8 fall flag", d, 16'h0020);
    chk("R13 disabled no irq", {9'd0, irq}, 16'h0000);
    swr(3'd6, 16'h0020);
    ext[5] = 1; repeat (3) @(negedge clk);
    sread(3'd6, d); chk("R8 rise ignored", d, 16'h0000);
  endtask

  task automatic t_both;
    logic [15:0] d;
    swr(3'd0, 16'h3000);
    ext[6] = 0; repeat (3) @(negedge clk);
    sread(3'd6, d); chk("R9 both falling", d, 16'h0040);
    swr(3'd6, 16'h0040);
    ext[6] = 1; repeat (3) @(negedge clk);
    sread(3'd6, d); chk("R9 both rising", d, 16'h0040);
    swr(3'd6, 16'h0040);
  endtask

  task automatic t_edge_wins;
    logic [15:0] d;
    ext[6] = 0; repeat (3) @(negedge clk);
    @(negedge clk); ext[6] = 1;
    @(negedge clk);
    swr(3'd6, 16'h0040);
    sread(3'd6, d); chk("R11 edge beats clear", d, 16'h0040);
    swr(3'd6, 16'h0040);
    sread(3'd6, d); chk("R11 later clear", d, 16'h0000);
  endtask

  task automatic t_dir;
    logic [15:0] d;
    swr(3'd0, 16'h0040); swr(3'd4, 16'h00F7); swr(3'd2, 16'h0008);
    ext[3] = 0; repeat (3) @(negedge clk);
    swr(3'd6, 16'h00FE);
    swr(3'd4, 16'h00FF); repeat (3) @(negedge clk);
    sread(3'd6, d); chk("R12 output edge flag", d, 16'h0008);
    sread(3'd5, d); chk("R12 pad level read", d & 16'h0008, 16'h0008);
    swr(3'd6, 16'h0008); swr(3'd2, 16'h0000); ext[3] = 1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset(); t_access(); t_output(); t_pindata(); t_level();
    t_rise(); t_fall(); t_both(); t_edge_wins(); t_dir();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule